// File: doc/BRIEF.md
# Row-Buffered DRAM Array Model

A synchronous, synthesizable model of a small dynamic memory chip. Storage is a grid of multi-bit supercells, ROWS by COLS, each DW bits wide (4 by 4 by 8 bits by default). A single narrow address port is time-shared. A row-strobe command carries a row index and copies that whole row into an internal row buffer. Each later column-strobe command carries a column index and either reads one supercell from the buffer or writes one into it.

Page-mode access is native. Any number of column strobes may follow one row strobe while that row stays open. A modified row is written back to the array when it is closed, either by a precharge command or by a row strobe to another row. Read data comes out one clock after the column strobe, together with a one-cycle valid pulse. A column strobe issued while no row is open has no effect on storage. Instead it raises a one-cycle error pulse.

Top module: `dram_rowbuf_core`

## Requirements
- R1: While reset is applied, and once it has been released, row_open_o, rvalid_o and err_o are all 0. The address width is log2 of the larger of ROWS and COLS, and is at least 1.
- R2: Commands are encoded on cmd_i as 0 = no operation, 1 = row strobe, 2 = column strobe, 3 = precharge. A row strobe opens the row given on addr_i, and row_open_o is 1 from the following cycle.
- R3: A column strobe with we_i = 0 while a row is open gives rvalid_o = 1 in the next cycle. In that cycle rdata_o holds the current contents of supercell (open row, addr_i).
- R4: A column strobe with we_i = 1 while a row is open stores wdata_i into the addressed supercell of the open row and gives no rvalid_o. A later read of that cell returns the new value.
- R5: Page mode: after one row strobe, any sequence of column strobes, back to back or spread out, reaches the same open row with no further row strobe.
- R6: A column strobe while no row is open gives err_o = 1 in the next cycle and rvalid_o = 0 in that cycle. It changes no stored data.
- R7: Closing a row, by precharge or by a row strobe to another row, preserves every write made while it was open. Reopening it later returns the written values.
- R8: A row strobe to the row that is already open keeps its buffered writes.
- R9: A precharge while no row is open changes nothing: row_open_o stays 0 and err_o stays 0.
- R10: rvalid_o is 1 only in the cycle after a read column strobe to an open row. rvalid_o and err_o are never 1 together.
- R11: Reset closes any open row and discards writes made to it that were not yet written back. Array contents are not cleared, so rows closed before the reset read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_i | input | 2 | Command: 0 nop, 1 row strobe, 2 column strobe, 3 precharge |
| we_i | input | 1 | Column strobe direction: 1 write, 0 read |
| addr_i | input | AW | Row index with a row strobe, column index with a column strobe |
| wdata_i | input | DW | Write data for a write column strobe |
| rdata_o | output | DW | Read data, valid while rvalid_o is 1 |
| rvalid_o | output | 1 | One-cycle pulse qualifying rdata_o |
| err_o | output | 1 | One-cycle pulse for a column strobe with no open row |
| row_open_o | output | 1 | A row is currently held in the row buffer |

## Verification
A row buffer loaded from the wrong row, or a stale cell, shows up on the first read strobe after it, one clock later, as a miscompare on rdata_o. A lost write-back stays hidden while the row is open. It only appears after the row has been closed and reopened, so the stimulus cycles rows through precharge, row switches, same-row reopen and a mid-run reset before it reads them back. A wrong open flag shows at once on row_open_o. It then shows as a missing or spurious pulse on err_o or rvalid_o at the next column strobe.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ROW = 2'd1,
    CMD_COL = 2'd2,
    CMD_PRE = 2'd3
  } dram_cmd_e;
endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  parameter int AW   = 2,
  localparam int RB  = COLS * DW
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_row_i,
  input  logic [RB-1:0] wr_data_i,
  input  logic [AW-1:0] rd_row_i,
  output logic [RB-1:0] rd_data_o
);
  logic [RB-1:0] mem_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_we;
    assign row_we = wr_en_i && (wr_row_i == AW'(r));
    always_ff @(posedge clk) begin
      if (row_we) mem_q[r] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (rd_row_i == AW'(r)) rd_data_o = mem_q[r];
    end
  end
endmodule

// File: rtl/dram_row_buffer.sv
module dram_row_buffer #(
  parameter int COLS = 4,
  parameter int DW   = 8,
  parameter int AW   = 2,
  localparam int RB  = COLS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en_i,
  input  logic          load_keep_i,
  input  logic [RB-1:0] load_data_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] col_i,
  input  logic [DW-1:0] wdata_i,
  output logic [RB-1:0] row_data_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] cells_q [COLS];
  logic [DW-1:0] cells_d [COLS];
  logic [DW-1:0] rd_sel;
  logic [DW-1:0] rdata_q;

  always_comb begin
    for (int c = 0; c < COLS; c++) cells_d[c] = cells_q[c];
    if (load_en_i && !load_keep_i) begin
      for (int c = 0; c < COLS; c++) cells_d[c] = load_data_i[c*DW +: DW];
    end else if (wr_en_i) begin
      for (int c = 0; c < COLS; c++) begin
        if (col_i == AW'(c)) cells_d[c] = wdata_i;
      end
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < COLS; c++) begin
      if (col_i == AW'(c)) rd_sel = cells_q[c];
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < COLS; c++) cells_q[c] <= cells_d[c];
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) rdata_q <= rd_sel;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_flat
    assign row_data_o[c*DW +: DW] = cells_q[c];
  end
  assign rdata_o = rdata_q;

  // R4: a written cell holds the write data on the next cycle
  p_col_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !load_en_i) |=> (rd_sel == $past(wdata_i)) || (col_i != $past(col_i)));
endmodule

// File: rtl/dram_cmd_ctrl.sv
module dram_cmd_ctrl
  import dram_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmd_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic          load_en_o,
  output logic          load_keep_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_row_o,
  output logic          col_rd_o,
  output logic          col_wr_o,
  output logic          open_o,
  output logic          rvalid_o,
  output logic          err_o
);
  dram_cmd_e cmd;
  logic is_row, is_col, is_pre;
  logic open_q, open_d;
  logic dirty_q, dirty_d;
  logic [AW-1:0] row_q, row_d;
  logic rvalid_q, rvalid_d;
  logic err_q, err_d;

  assign cmd    = dram_cmd_e'(cmd_i);
  assign is_row = (cmd == CMD_ROW);
  assign is_col = (cmd == CMD_COL);
  assign is_pre = (cmd == CMD_PRE);

  always_comb begin
    load_en_o   = is_row;
    load_keep_o = open_q && (addr_i == row_q);
    wb_en_o     = (is_row || is_pre) && open_q && dirty_q;
    wb_row_o    = row_q;
    col_rd_o    = is_col && !we_i && open_q;
    col_wr_o    = is_col && we_i && open_q;

    open_d   = open_q;
    row_d    = row_q;
    dirty_d  = dirty_q;
    if (is_row) begin
      open_d  = 1'b1;
      row_d   = addr_i;
      dirty_d = 1'b0;
    end else if (is_pre) begin
      open_d  = 1'b0;
      dirty_d = 1'b0;
    end else if (col_wr_o) begin
      dirty_d = 1'b1;
    end
    rvalid_d = col_rd_o;
    err_d    = is_col && !open_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      dirty_q  <= 1'b0;
      row_q    <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      open_q   <= open_d;
      dirty_q  <= dirty_d;
      row_q    <= row_d;
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
    end
  end

  assign open_o   = open_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;

  p_open_after_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'd1) |=> open_o);
  p_read_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'd2 && !we_i && open_o) |=> rvalid_o);
  p_closed_col_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'd2 && !open_o) |=> (err_o && !rvalid_o));
  p_closed_after_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'd3) |=> !open_o);
  p_idle_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'd3 && !open_o) |=> (!open_o && !err_o));
  p_valid_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> $past(cmd_i == 2'd2 && !we_i && open_o));
  p_excl_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rvalid_o && err_o));
endmodule

// File: rtl/dram_rowbuf_core.sv
module dram_rowbuf_core #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  localparam int MAXD = (ROWS > COLS) ? ROWS : COLS,
  localparam int AW   = (MAXD > 1) ? $clog2(MAXD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmd_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          err_o,
  output logic          row_open_o
);
  localparam int RB = COLS * DW;

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic          load_en, load_keep, wb_en, col_rd, col_wr;
  logic [AW-1:0] wb_row;
  logic [RB-1:0] arr_rd_data, buf_row_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  dram_cmd_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cmd_i      (cmd_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .load_en_o  (load_en),
    .load_keep_o(load_keep),
    .wb_en_o    (wb_en),
    .wb_row_o   (wb_row),
    .col_rd_o   (col_rd),
    .col_wr_o   (col_wr),
    .open_o     (row_open_o),
    .rvalid_o   (rvalid_o),
    .err_o      (err_o)
  );

  dram_cell_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW)) u_array (
    .clk      (clk),
    .wr_en_i  (wb_en),
    .wr_row_i (wb_row),
    .wr_data_i(buf_row_data),
    .rd_row_i (addr_i),
    .rd_data_o(arr_rd_data)
  );

  dram_row_buffer #(.COLS(COLS), .DW(DW), .AW(AW)) u_rowbuf (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_en_i  (load_en),
    .load_keep_i(load_keep),
    .load_data_i(arr_rd_data),
    .wr_en_i    (col_wr),
    .rd_en_i    (col_rd),
    .col_i      (addr_i),
    .wdata_i    (wdata_i),
    .row_data_o (buf_row_data),
    .rdata_o    (rdata_o)
  );

  // R1: outputs quiet while reset is applied
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_s |-> (!row_open_o && !rvalid_o && !err_o));
endmodule

// File: tb/dram_rowbuf_core_test.sv
module dram_rowbuf_core_test;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int DW   = 8;
  localparam int AW   = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cmd_i;
  logic          we_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o, err_o, row_open_o;

  int vectors = 0;
  int errors  = 0;

  int mem_m [ROWS][COLS];
  int buf_m [COLS];
  int open_m, row_m;

  always #4 clk = ~clk;

  dram_rowbuf_core #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .err_o(err_o), .row_open_o(row_open_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one command per clock; model updated from its state before the edge
  task automatic step(int cmd, int we, int addr, int data);
    int exp_rv, exp_err, exp_rd;
    string tag;
    exp_rv = 0; exp_err = 0; exp_rd = 0; tag = "R5";
    cmd_i = cmd[1:0]; we_i = we[0]; addr_i = addr[AW-1:0]; wdata_i = data[DW-1:0];
    case (cmd)
      1: begin
        tag = (open_m != 0 && row_m == addr) ? "R8" : "R2";
        if (open_m != 0) for (int c = 0; c < COLS; c++) mem_m[row_m][c] = buf_m[c];
        for (int c = 0; c < COLS; c++) buf_m[c] = mem_m[addr][c];
        open_m = 1; row_m = addr;
      end
      2: begin
        if (open_m == 0) begin exp_err = 1; tag = "R6"; end
        else if (we != 0) begin buf_m[addr] = data; tag = "R4"; end
        else begin exp_rv = 1; exp_rd = buf_m[addr]; tag = "R3"; end
      end
      3: begin
        tag = (open_m != 0) ? "R7" : "R9";
        if (open_m != 0) for (int c = 0; c < COLS; c++) mem_m[row_m][c] = buf_m[c];
        open_m = 0;
      end
      default: tag = "R10";
    endcase
    @(posedge clk);
    @(negedge clk);
    check(tag, "rvalid_o", int'(rvalid_o), exp_rv);
    check(tag, "err_o", int'(err_o), exp_err);
    check(tag, "row_open_o", int'(row_open_o), open_m);
    if (exp_rv != 0) check(tag, "rdata_o", int'(rdata_o), exp_rd);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_i = 2'd0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
    open_m = 0;
    repeat (2) @(negedge clk);
    check("R1", "row_open_o in reset", int'(row_open_o), 0);
    check("R1", "rvalid_o in reset", int'(rvalid_o), 0);
    check("R1", "err_o in reset", int'(err_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "row_open_o after reset", int'(row_open_o), 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9 and R6 before anything is open
    step(3, 0, 0, 0);
    step(2, 0, 1, 0);
    step(2, 1, 2, 8'h33);
    // fill every cell (R4), closing with precharge (R7)
    for (int r = 0; r < ROWS; r++) begin
      step(1, 0, r, 0);
      for (int c = 0; c < COLS; c++) step(2, 1, c, 16 * r + c + 1);
      step(3, 0, 0, 0);
    end
    // page-mode reads, back to back (R5, R3)
    step(1, 0, 2, 0);
    for (int c = 0; c < COLS; c++) step(2, 0, c, 0);
    // write then read same cell, spread out (R4, R5)
    step(2, 1, 1, 8'hA5);
    step(0, 0, 0, 0);
    step(2, 0, 1, 0);
    // same-row reopen keeps write (R8)
    step(2, 1, 3, 8'h5C);
    step(1, 0, 2, 0);
    step(2, 0, 3, 0);
    // switch row writes back old one (R7)
    step(1, 0, 0, 0);
    step(1, 0, 2, 0);
    step(2, 0, 3, 0);
    step(2, 0, 1, 0);
    step(3, 0, 0, 0);
    // R11: dirty open row lost at reset, closed rows kept
    step(1, 0, 1, 0);
    step(2, 1, 0, 8'hEE);
    do_reset();
    step(2, 0, 0, 0);
    step(1, 0, 1, 0);
    step(2, 0, 0, 0);
    step(1, 0, 2, 0);
    step(2, 0, 1, 0);
    // random stream against the model
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 2)      step(1, 0, $urandom_range(0, ROWS - 1), 0);
      else if (k < 7) step(2, $urandom_range(0, 1), $urandom_range(0, COLS - 1),
                           $urandom_range(0, 255));
      else if (k < 8) step(3, 0, 0, 0);
      else            step(0, 0, 0, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule